// File: doc/BRIEF.md
# Raw SWD bit sequencer

This block clocks a short run of raw bits on a two-wire serial debug port. It either drives them onto the data line or samples them from it. Bit timing comes from a programmable divider. Frames, parity and acknowledge codes are handled by the layer above; this block only moves bits.

A command word sets the bit count and the direction. Outgoing bits are fetched a byte at a time through an index/data pair. Captured bits are returned a byte at a time with a valid strobe. A second mode, selected by an input, drives a long sequence whose bit count is a full 32-bit value. It is used for line resets and similar patterns.

Each run is launched by a one-cycle start. Busy stays high until the closing done pulse.

Top module: `swd_seq_engine`

## Requirements
- R1: Command bits [5:0] hold the bit count; the value 0 selects 64 bits, any other value selects that many bits (1 to 63).
- R2: Command bit 6 selects the direction: 1 captures bits from `swdio_i`, 0 drives bits on `swdio_o`.
- R3: Driven bits go out least significant bit first; bit b of the run is bit (b mod 8) of the byte at index b/8, which is read from `wr_data_i` while `wr_idx_o` shows that index.
- R4: When capturing, every complete group of 8 bits is returned on `rd_data_o` with a one-cycle `rd_valid_o`, first bit in bit 0, and `rd_idx_o` gives the group number. A final group of k<8 bits is right-aligned in bits [k-1:0] with the upper bits zero. `rd_valid_o` never rises in drive mode.
- R5: Each bit period keeps `swclk_o` low for D+1 clock cycles and then high for D+1 cycles, where D is `div_i` sampled at start. Later changes of `div_i` have no effect on a running sequence. `swclk_o` idles high.
- R6: Drive data changes only when the low phase begins. Capture samples `swdio_i` on the clock edge that ends the low phase.
- R7: With `line_mode_i` high at start, `line_len_i` bits are driven from the byte stream. The command word, including its direction bit, is ignored.
- R8: `swdio_oe_o` is low for the whole of a capture run. It is high during drive and line runs and while idle.
- R9: `busy_o` rises in the cycle after an accepted start and falls when `done_o` pulses for one cycle. `done_o` follows the end of the last high phase.
- R10: A start that arrives while busy is ignored; the run in progress keeps its count, direction and timing.
- R11: After reset the block is idle: `busy_o`, `done_o` and `rd_valid_o` are low, while `swclk_o`, `swdio_o` and `swdio_oe_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a run |
| cmd_i | input | 7 | [5:0] bit count (0 = 64), [6] capture when 1 |
| line_mode_i | input | 1 | Long drive sequence with 32-bit count |
| line_len_i | input | 32 | Bit count for line mode, at least 1 |
| div_i | input | 8 | Extra cycles per half period |
| wr_idx_o | output | 29 | Index of the byte to be driven next |
| wr_data_i | input | 8 | Byte at `wr_idx_o` |
| rd_data_o | output | 8 | Captured byte |
| rd_idx_o | output | 29 | Index of the captured byte |
| rd_valid_o | output | 1 | Captured byte strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, one cycle |
| swclk_o | output | 1 | Serial clock |
| swdio_o | output | 1 | Serial data out |
| swdio_oe_o | output | 1 | Serial data output enable |
| swdio_i | input | 1 | Serial data in |

## Verification
The assertions assume that a line-mode start always carries a non-zero `line_len_i`, because the remaining-bit counter is taken to be non-zero while busy. They also assume that `wr_data_i` is a combinational function of `wr_idx_o`. The bench only issues line runs of 51 and 100 bits. It serves the write bytes from a small table addressed by `wr_idx_o`. It changes `swdio_i` only at falling clock edges, well before the sampling edge. It changes `div_i` right after each start, so that the divider latch is exercised without breaking the timer's bound.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  localparam int unsigned CMD_W       = 7;
  localparam int unsigned CMD_CNT_W   = 6;
  localparam int unsigned CMD_DIR_BIT = 6;
  localparam int unsigned MAX_SHORT   = 64;
endpackage

// File: rtl/swd_half_timer.sv
module swd_half_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      div_q <= div_i;
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_WITHIN_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= div_q); // R5
endmodule

// File: rtl/swd_byte_shifter.sv
module swd_byte_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       shift_i,
  input  logic       sample_i,
  input  logic       emit_i,
  input  logic [2:0] emit_shift_i,
  input  logic [7:0] wr_byte_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic [7:0] rd_byte_o,
  output logic       rd_valid_o
);
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      sdo_o <= 1'b1;
    end else if (load_i) begin
      sh_q  <= {1'b0, wr_byte_i[7:1]};
      sdo_o <= wr_byte_i[0];
    end else if (shift_i) begin
      sh_q  <= {1'b0, sh_q[7:1]};
      sdo_o <= sh_q[0];
    end else if (sample_i) begin
      sh_q  <= {sdi_i, sh_q[7:1]};
    end
  end

  // partial last byte: drop stale low bits, top fills with zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_byte_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= emit_i;
      if (emit_i) rd_byte_o <= sh_q >> emit_shift_i;
    end
  end

  AST_LOAD_NOT_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && sample_i)); // R2
  AST_EMIT_NOT_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i |-> !shift_i && !load_i); // R4
endmodule

// File: rtl/swd_seq_engine.sv
module swd_seq_engine
  import swd_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned DIV_W = 8,
  localparam int unsigned IDX_W = CNT_W - 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             line_mode_i,
  input  logic [CNT_W-1:0] line_len_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [IDX_W-1:0] wr_idx_o,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       rd_data_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             rd_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             swclk_o,
  output logic             swdio_o,
  output logic             swdio_oe_o,
  input  logic             swdio_i
);
  logic             busy_q, done_q, swclk_q, oe_q, cap_q;
  phase_e           phase_q;
  logic [CNT_W-1:0] left_q;
  logic [2:0]       pos_q;
  logic [IDX_W-1:0] wr_idx_q, rd_cnt_q, rd_idx_q;

  logic             start_ok, cap_new, tick, end_low, end_high, last, byte_end;
  logic [CNT_W-1:0] total;
  logic [CMD_CNT_W-1:0] cnt_field;
  logic             ld, sh, smp, emit;

  assign cnt_field = cmd_i[CMD_CNT_W-1:0];
  assign start_ok  = start_i && !busy_q;
  assign cap_new   = cmd_i[CMD_DIR_BIT] && !line_mode_i;

  always_comb begin
    if (line_mode_i)         total = line_len_i;
    else if (cnt_field == 0) total = CNT_W'(MAX_SHORT);
    else                     total = CNT_W'(cnt_field);
  end

  swd_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_ok),
    .div_i  (div_i),
    .run_i  (busy_q),
    .tick_o (tick)
  );

  assign end_low  = busy_q && (phase_q == PH_LOW) && tick;
  assign end_high = busy_q && (phase_q == PH_HIGH) && tick;
  assign last     = (left_q == CNT_W'(1));
  assign byte_end = (pos_q == 3'd7);

  assign ld   = (start_ok && !cap_new) || (end_high && !last && byte_end && !cap_q);
  assign sh   = end_high && !last && !byte_end && !cap_q;
  assign smp  = end_low && cap_q;
  assign emit = end_high && cap_q && (byte_end || last);

  swd_byte_shifter u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (ld),
    .shift_i      (sh),
    .sample_i     (smp),
    .emit_i       (emit),
    .emit_shift_i (3'd7 - pos_q),
    .wr_byte_i    (wr_data_i),
    .sdi_i        (swdio_i),
    .sdo_o        (swdio_o),
    .rd_byte_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      swclk_q  <= 1'b1;
      oe_q     <= 1'b1;
      cap_q    <= 1'b0;
      phase_q  <= PH_LOW;
      left_q   <= '0;
      pos_q    <= '0;
    end else begin
      done_q <= end_high && last;
      if (start_ok) begin
        busy_q  <= 1'b1;
        swclk_q <= 1'b0;
        oe_q    <= !cap_new;
        cap_q   <= cap_new;
        phase_q <= PH_LOW;
        left_q  <= total;
        pos_q   <= '0;
      end else if (end_low) begin
        swclk_q <= 1'b1;
        phase_q <= PH_HIGH;
      end else if (end_high) begin
        left_q <= left_q - 1'b1;
        pos_q  <= pos_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b1;
        end else begin
          swclk_q <= 1'b0;
          phase_q <= PH_LOW;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx_q <= '0;
      rd_cnt_q <= '0;
      rd_idx_q <= '0;
    end else begin
      if (end_high && last)  wr_idx_q <= '0;
      else if (ld)           wr_idx_q <= wr_idx_q + 1'b1;
      if (start_ok)          rd_cnt_q <= '0;
      else if (emit)         rd_cnt_q <= rd_cnt_q + 1'b1;
      if (emit)              rd_idx_q <= rd_cnt_q;
    end
  end

  assign wr_idx_o   = wr_idx_q;
  assign rd_idx_o   = rd_idx_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign swclk_o    = swclk_q;
  assign swdio_oe_o = oe_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R9
  AST_CLK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> swclk_o); // R5
  AST_OE_OFF_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cap_q |-> !swdio_oe_o); // R8
  AST_DOUT_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && swclk_o |-> $stable(swdio_o)); // R6
  AST_RD_CAPTURE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> cap_q); // R4
  AST_LEFT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> left_q != '0); // R1
  AST_WR_IDX_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> wr_idx_o == '0); // R3
endmodule

// File: tb/swd_seq_engine_test.sv
module swd_seq_engine_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  cmd_i = '0;
  logic        line_mode_i = 1'b0;
  logic [31:0] line_len_i = '0;
  logic [7:0]  div_i = '0;
  logic [28:0] wr_idx_o;
  logic [7:0]  wr_data_i;
  logic [7:0]  rd_data_o;
  logic [28:0] rd_idx_o;
  logic        rd_valid_o, busy_o, done_o, swclk_o, swdio_o, swdio_oe_o;
  logic        swdio_i = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] wr_mem [16];
  logic       cap_bits [128];

  always #10 clk_i = ~clk_i;

  assign wr_data_i = wr_mem[wr_idx_o[3:0]];

  swd_seq_engine uut (
    .clk_i, .rst_ni, .start_i, .cmd_i, .line_mode_i, .line_len_i, .div_i,
    .wr_idx_o, .wr_data_i, .rd_data_o, .rd_idx_o, .rd_valid_o, .busy_o,
    .done_o, .swclk_o, .swdio_o, .swdio_oe_o, .swdio_i
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle-accurate reference run; ign_k: cycle at which a start is pulsed while busy
  task automatic run(input logic line, input logic [6:0] cmd, input int len,
                     input int div, input int ign_k);
    int n, p, b, r, cb;
    logic cap;
    logic [7:0] exp_byte;
    n   = line ? len : (cmd[5:0] == 0 ? 64 : int'(cmd[5:0]));
    cap = !line && cmd[6];
    p   = 2 * (div + 1);
    @(negedge clk_i);
    start_i = 1'b1; cmd_i = cmd; line_mode_i = line;
    line_len_i = 32'(len); div_i = 8'(div);
    @(negedge clk_i);
    start_i = 1'b0;
    div_i = 8'(div) ^ 8'h03;       // must not affect the running sequence (R5)
    for (int k = 0; k <= n * p + 1; k++) begin
      b = k / p; r = k % p;
      if (b < n) swdio_i = cap_bits[b];
      if (k == ign_k) begin
        start_i = 1'b1; cmd_i = 7'h45; line_mode_i = 1'b0;   // R10
      end else start_i = 1'b0;
      if (k < n * p) begin
        chk("R9 busy", 32'(busy_o), 1);
        chk("R9 done", 32'(done_o), 0);
        chk("R5 swclk", 32'(swclk_o), 32'(r >= div + 1));
        chk("R8 oe", 32'(swdio_oe_o), 32'(!cap));
        if (!cap) chk("R3 R6 R7 data", 32'(swdio_o), 32'(wr_mem[(b / 8) % 16][b % 8]));
      end else if (k == n * p) begin
        chk("R9 done", 32'(done_o), 1);
        chk("R9 busy", 32'(busy_o), 0);
        chk("R5 idle clk", 32'(swclk_o), 1);
        chk("R8 idle oe", 32'(swdio_oe_o), 1);
      end else begin
        chk("R9 done one cycle", 32'(done_o), 0);
        chk("R10 no restart", 32'(busy_o), 0);
      end
      if (k > 0 && r == 0 && cap && ((b % 8) == 0 || b == n)) begin
        cb = b - 1;
        exp_byte = '0;
        for (int j = (cb / 8) * 8; j <= cb; j++) exp_byte[j % 8] = cap_bits[j];
        chk("R4 rd_valid", 32'(rd_valid_o), 1);
        chk("R4 R6 rd_data", 32'(rd_data_o), 32'(exp_byte));
        chk("R4 rd_idx", 32'(rd_idx_o), 32'(cb / 8));
      end else begin
        chk("R4 no rd_valid", 32'(rd_valid_o), 0);
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) wr_mem[i] = 8'(i * 37 + 91);
    for (int i = 0; i < 128; i++) cap_bits[i] = 1'(((i * 13 + 5) >> 2) ^ i);
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 busy", 32'(busy_o), 0);
    chk("R11 done", 32'(done_o), 0);
    chk("R11 rd_valid", 32'(rd_valid_o), 0);
    chk("R11 swclk", 32'(swclk_o), 1);
    chk("R11 swdio", 32'(swdio_o), 1);
    chk("R11 oe", 32'(swdio_oe_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run(1'b0, 7'h05, 0, 0, -1);      // R2 drive, 5 bits, fastest
    run(1'b0, 7'h00, 0, 1, -1);      // R1 zero means 64
    run(1'b0, 7'h4D, 0, 2, -1);      // R4 capture 13 bits, partial byte
    run(1'b0, 7'h50, 0, 0, -1);      // R4 capture 16 bits exact
    run(1'b0, 7'h40, 0, 0, -1);      // R1 capture 64
    run(1'b1, 7'h4A, 100, 0, -1);    // R7 line mode, direction ignored
    run(1'b1, 7'h00, 51, 1, -1);     // R7 line mode 51 bits
    run(1'b0, 7'h09, 0, 3, 10);      // R10 start while busy
    run(1'b0, 7'h41, 0, 0, 1);       // R4 single captured bit, R10
    run(1'b0, 7'h3F, 0, 0, -1);      // R1 63 bits
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule